// File: doc/BRIEF.md
# Chip Erase Retry Controller

This block sits on the programmer side of a byte-wide electrically erasable read-only memory and runs a complete chip erase with confirmation. A single start pulse launches the job. The block drives the chip-select, output-enable and program-strobe lines, the address and write-data buses, a request for the raised A9 voltage, and a request for the supply levels. It reads the returned byte bus itself. It reports the result through done, pass and an attempt count.

Two erase methods are available, chosen at start. In the high-voltage method, A9 is raised with the address at zero, and one long strobe is sent. In the command method, two bus writes are sent: a short strobe to the unlock address, then a long strobe that carries the erase code. After each erase the block requests the low verify supply and reads the array upward from address zero. It retries at the first byte that is not all ones, and it stops after a fixed number of attempts. Every pulse width and wait is a clock-cycle-count parameter.

Top module: `erase_retry_ctrl`

## Requirements
- R1: After reset the outputs are busy_o=0, done_o=0, pass_o=0, attempts_o=0, ce_n_o=1, oe_n_o=1, pgm_n_o=1, hv_sup_o=0 and a9_hv_o=0.
- R2: A start_i pulse seen while idle has two effects on the next cycle. busy_o is 1 and attempts_o is 1. The programming supply is requested (hv_sup_o=1) with the strobe still high. No strobe falls until SETUP_CYC cycles have passed.
- R3: With method_i=0 (high-voltage), each attempt drives a9_hv_o=1 with addr_o=0. It sends exactly one strobe (pgm_n_o low) of LONG_CYC cycles and data_o=0xFF.
- R4: With method_i=1 (command), each attempt first sends a SHORT_CYC-cycle strobe with addr_o=0x5555 and data_o=0xAA. It then sends a LONG_CYC-cycle strobe with addr_o=0x2AAA and data_o=0x10. a9_hv_o stays 0.
- R5: pgm_n_o is low only while oe_n_o=1, ce_n_o=0 and hv_sup_o=1. addr_o and data_o stay constant through each strobe and for HOLD_CYC cycles after it rises.
- R6: After each erase the block drops hv_sup_o to 0. It then lowers oe_n_o and reads addresses 0, 1, 2, … in that order, one per cycle.
- R7: When a read returns a byte other than 0xFF, the scan ends at that address. If attempts_o is below MAX_TRIES, attempts_o increments and the erase is repeated.
- R8: If every address up to the last reads 0xFF, done_o pulses with pass_o=1. attempts_o holds the number of erases made.
- R9: If the check still fails on attempt MAX_TRIES, done_o pulses with pass_o=0 and attempts_o=MAX_TRIES. No further strobe is sent.
- R10: A start_i pulse while busy_o=1 has no effect. The run's strobe count and final attempts_o are unchanged.
- R11: done_o is high for exactly one cycle and never together with busy_o. pass_o and attempts_o keep their values after done_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin a run |
| method_i | input | 1 | Erase method, sampled at start: 0 high-voltage, 1 command |
| data_i | input | 8 | Byte read back from the array at addr_o |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result of the last run: 1 blank, 0 gave up |
| attempts_o | output | $clog2(MAX_TRIES+1) | Erase attempts used in the current or last run |
| addr_o | output | AW | Array address |
| data_o | output | 8 | Write byte presented during strobes |
| ce_n_o | output | 1 | Active-low chip select |
| oe_n_o | output | 1 | Active-low output enable (low only during the blank scan) |
| pgm_n_o | output | 1 | Active-low program/erase strobe |
| hv_sup_o | output | 1 | Supply request: 1 programming levels, 0 verify levels |
| a9_hv_o | output | 1 | Request to drive A9 to its erase high voltage |

## Verification
The properties assume that data_i settles to the byte at addr_o within the same cycle. The bench array model is therefore a combinational lookup: a chosen address returns a non-blank byte until a given number of long strobes has been seen. The properties also assume that start_i pulses do not depend on internal state. The bench drives start_i for one cycle, on the falling clock edge, and once deliberately pulses it mid-run. Reset is applied from time zero, so no property sees pre-reset values.

// File: rtl/erc_pkg.sv
package erc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PREP,
      ST_CMD,
      ST_CMD_HOLD,
      ST_ERASE,
      ST_ERASE_HOLD,
      ST_SETTLE,
      ST_SCAN,
      ST_FINISH
   } erc_state_e;

   typedef enum logic {
      METH_HV  = 1'b0,
      METH_CMD = 1'b1
   } erc_method_e;

   localparam logic [14:0] UNLOCK_ADDR = 15'h5555;
   localparam logic [7:0]  UNLOCK_DATA = 8'hAA;
   localparam logic [14:0] ERASE_ADDR  = 15'h2AAA;
   localparam logic [7:0]  ERASE_DATA  = 8'h10;
   localparam logic [7:0]  BLANK_BYTE  = 8'hFF;

endpackage

// File: rtl/erc_timer.sv
module erc_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         expired_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/erc_scan.sv
module erc_scan #(
   parameter int AW         = 18,
   parameter bit EARLY_STOP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic [7:0]    data_i,
   output logic [AW-1:0] addr_o,
   output logic          end_o,
   output logic          blank_o
);

   import erc_pkg::*;

   logic [AW-1:0] addr_q;
   logic          cur_bad;
   logic          last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (!en_i)
         addr_q <= '0;
      else
         addr_q <= addr_q + AW'(1);
   end

   assign cur_bad = (data_i != BLANK_BYTE);
   assign last    = &addr_q;
   assign addr_o  = addr_q;

   generate
      if (EARLY_STOP) begin : g_early
         assign end_o   = en_i & (cur_bad | last);
         assign blank_o = ~cur_bad;
      end else begin : g_full
         logic dirty_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dirty_q <= 1'b0;
            else if (!en_i)
               dirty_q <= 1'b0;
            else
               dirty_q <= dirty_q | cur_bad;
         end
         assign end_o   = en_i & last;
         assign blank_o = ~dirty_q & ~cur_bad;
      end
   endgenerate

endmodule

// File: rtl/erase_retry_ctrl.sv
module erase_retry_ctrl #(
   parameter int AW         = 18,
   parameter int MAX_TRIES  = 20,
   parameter int SETUP_CYC  = 250,
   parameter int SHORT_CYC  = 12500,
   parameter int LONG_CYC   = 12500000,
   parameter int HOLD_CYC   = 250,
   parameter bit EARLY_STOP = 1'b1,
   localparam int CW        = $clog2(MAX_TRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          method_i,
   input  logic [7:0]    data_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic [CW-1:0] attempts_o,
   output logic [AW-1:0] addr_o,
   output logic [7:0]    data_o,
   output logic          ce_n_o,
   output logic          oe_n_o,
   output logic          pgm_n_o,
   output logic          hv_sup_o,
   output logic          a9_hv_o
);

   import erc_pkg::*;

   localparam int MAX_A = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
   localparam int MAX_B = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
   localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TW    = $clog2(MAXD + 1);

   if (AW < 15) begin : g_chk_aw
      $error("erase_retry_ctrl: AW must reach the command addresses");
   end
   if (MAX_TRIES < 1) begin : g_chk_tries
      $error("erase_retry_ctrl: MAX_TRIES must be at least 1");
   end
   if (SETUP_CYC < 1 || HOLD_CYC < 1 || SHORT_CYC < 1) begin : g_chk_dur
      $error("erase_retry_ctrl: every duration must be at least one cycle");
   end
   if (LONG_CYC <= SHORT_CYC) begin : g_chk_order
      $error("erase_retry_ctrl: erase strobe must outlast command strobe");
   end

   erc_state_e    state_q, state_d;
   erc_method_e   meth_q;
   logic [CW-1:0] tries_q;
   logic          pass_q;
   logic          tmr_exp;
   logic          tmr_load;
   logic [TW-1:0] dur;
   logic          scan_en;
   logic          scan_end;
   logic          scan_blank;
   logic [AW-1:0] scan_addr;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:       if (start_i) state_d = ST_PREP;
         ST_PREP:       if (tmr_exp) state_d = (meth_q == METH_CMD) ? ST_CMD : ST_ERASE;
         ST_CMD:        if (tmr_exp) state_d = ST_CMD_HOLD;
         ST_CMD_HOLD:   if (tmr_exp) state_d = ST_ERASE;
         ST_ERASE:      if (tmr_exp) state_d = ST_ERASE_HOLD;
         ST_ERASE_HOLD: if (tmr_exp) state_d = ST_SETTLE;
         ST_SETTLE:     if (tmr_exp) state_d = ST_SCAN;
         ST_SCAN: begin
            if (scan_end) begin
               if (scan_blank || tries_q == CW'(MAX_TRIES))
                  state_d = ST_FINISH;
               else
                  state_d = ST_PREP;
            end
         end
         ST_FINISH:     state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_PREP, ST_SETTLE:        dur = TW'(SETUP_CYC);
         ST_CMD:                    dur = TW'(SHORT_CYC);
         ST_ERASE:                  dur = TW'(LONG_CYC);
         ST_CMD_HOLD, ST_ERASE_HOLD: dur = TW'(HOLD_CYC);
         default:                   dur = TW'(1);
      endcase
   end

   assign tmr_load = (state_d != state_q);

   erc_timer #(.W(TW)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .val_i     (dur - TW'(1)),
      .expired_o (tmr_exp)
   );

   assign scan_en = (state_q == ST_SCAN);

   erc_scan #(.AW(AW), .EARLY_STOP(EARLY_STOP)) i_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (scan_en),
      .data_i  (data_i),
      .addr_o  (scan_addr),
      .end_o   (scan_end),
      .blank_o (scan_blank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         meth_q  <= METH_HV;
         tries_q <= '0;
         pass_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            meth_q  <= erc_method_e'(method_i);
            tries_q <= CW'(1);
            pass_q  <= 1'b0;
         end else if (state_q == ST_SCAN && scan_end) begin
            if (scan_blank)
               pass_q <= 1'b1;
            else if (tries_q != CW'(MAX_TRIES))
               tries_q <= tries_q + CW'(1);
         end
      end
   end

   logic in_erase;
   logic in_cmd;
   assign in_erase = (state_q == ST_ERASE) || (state_q == ST_ERASE_HOLD);
   assign in_cmd   = (state_q == ST_CMD)   || (state_q == ST_CMD_HOLD);

   always_comb begin
      addr_o = '0;
      data_o = BLANK_BYTE;
      if (in_cmd) begin
         addr_o = AW'(UNLOCK_ADDR);
         data_o = UNLOCK_DATA;
      end else if (in_erase && meth_q == METH_CMD) begin
         addr_o = AW'(ERASE_ADDR);
         data_o = ERASE_DATA;
      end else if (scan_en) begin
         addr_o = scan_addr;
      end
   end

   assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_FINISH);
   assign done_o     = (state_q == ST_FINISH);
   assign pass_o     = pass_q;
   assign attempts_o = tries_q;
   assign ce_n_o     = (state_q == ST_IDLE) || (state_q == ST_FINISH);
   assign oe_n_o     = ~scan_en;
   assign pgm_n_o    = ~((state_q == ST_CMD) || (state_q == ST_ERASE));
   assign hv_sup_o   = (state_q == ST_PREP) || in_cmd || in_erase;
   assign a9_hv_o    = (meth_q == METH_HV) && ((state_q == ST_PREP) || in_erase);

endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
   parameter int AW        = 18,
   parameter int MAX_TRIES = 20,
   parameter int CW        = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          pass_o,
   input logic [CW-1:0] attempts_o,
   input logic [AW-1:0] addr_o,
   input logic          ce_n_o,
   input logic          oe_n_o,
   input logic          pgm_n_o,
   input logic          hv_sup_o,
   input logic          a9_hv_o
);

   assert_strobe_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pgm_n_o |-> (oe_n_o && !ce_n_o && hv_sup_o));

   assert_scan_low_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_o |-> (!hv_sup_o && pgm_n_o && !ce_n_o));

   assert_scan_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n_o && $past(!oe_n_o)) |-> (addr_o == $past(addr_o) + AW'(1)));

   assert_a9_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (a9_hv_o && !pgm_n_o) |-> (addr_o == '0));

   assert_attempt_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      attempts_o <= CW'(MAX_TRIES));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(attempts_o)));

   assert_busy_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (attempts_o >= $past(attempts_o)));

endmodule

bind erase_retry_ctrl erc_checker #(
   .AW(AW), .MAX_TRIES(MAX_TRIES), .CW(CW)
) i_erc_checker (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .pass_o(pass_o), .attempts_o(attempts_o),
   .addr_o(addr_o), .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .pgm_n_o(pgm_n_o),
   .hv_sup_o(hv_sup_o), .a9_hv_o(a9_hv_o)
);

// File: tb/test_erase_retry_ctrl.sv
module test_erase_retry_ctrl;

   localparam int AW    = 15;
   localparam int MAXT  = 20;
   localparam int SETUP = 3;
   localparam int SHORT = 4;
   localparam int LONG  = 9;
   localparam int HOLD  = 2;
   localparam int CW    = $clog2(MAXT + 1);
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          method_i = 1'b0;
   logic [7:0]    data_i;
   logic          busy_o, done_o, pass_o;
   logic [CW-1:0] attempts_o;
   logic [AW-1:0] addr_o;
   logic [7:0]    data_o;
   logic          ce_n_o, oe_n_o, pgm_n_o, hv_sup_o, a9_hv_o;

   always #4 clk = ~clk;

   erase_retry_ctrl #(
      .AW(AW), .MAX_TRIES(MAXT), .SETUP_CYC(SETUP), .SHORT_CYC(SHORT),
      .LONG_CYC(LONG), .HOLD_CYC(HOLD), .EARLY_STOP(1'b1)
   ) i_erase_retry_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .method_i(method_i),
      .data_i(data_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
      .attempts_o(attempts_o), .addr_o(addr_o), .data_o(data_o),
      .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .pgm_n_o(pgm_n_o),
      .hv_sup_o(hv_sup_o), .a9_hv_o(a9_hv_o)
   );

   int checks = 0;
   int fails  = 0;

   // array model state
   int need_erases = 0;
   int erase_base  = 0;
   int bad_addr    = 0;
   int cur_method  = 0;

   // monitor counters (cumulative)
   int n_short = 0, n_long = 0, n_reads = 0, n_done = 0;
   int v_strobe = 0, v_hold = 0, v_cmd = 0, v_hv = 0, v_width = 0, v_scan = 0, v_done = 0;
   int low_len = 0, hold_left = 0, exp_addr = 0;
   bit cmd_armed = 0;
   logic [AW-1:0] p_addr;
   logic [7:0]    p_data;
   logic          p_a9;

   always_comb begin
      if ((n_long - erase_base) >= need_erases)
         data_i = 8'hFF;
      else if (int'(addr_o) == bad_addr)
         data_i = 8'h00;
      else
         data_i = 8'hFF;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!pgm_n_o) begin
            if (low_len == 0) begin
               p_addr = addr_o; p_data = data_o; p_a9 = a9_hv_o;
            end else if (addr_o != p_addr || data_o != p_data) begin
               v_hold++;
            end
            if (!oe_n_o || ce_n_o || !hv_sup_o) v_strobe++;
            low_len++;
         end else begin
            if (low_len != 0) begin
               if (low_len == SHORT) begin
                  n_short++;
                  if (p_addr != 15'h5555 || p_data != 8'hAA) v_cmd++;
                  cmd_armed = 1;
               end else if (low_len == LONG) begin
                  n_long++;
                  if (cur_method == 1) begin
                     if (!cmd_armed || p_addr != 15'h2AAA || p_data != 8'h10 || p_a9) v_cmd++;
                  end else begin
                     if (!p_a9 || p_addr != '0 || p_data != 8'hFF) v_hv++;
                  end
                  cmd_armed = 0;
               end else begin
                  v_width++;
               end
               low_len = 0;
               hold_left = HOLD;
            end
            if (hold_left > 0) begin
               if (addr_o != p_addr || data_o != p_data) v_hold++;
               hold_left--;
            end
         end
         if (!oe_n_o) begin
            n_reads++;
            if (int'(addr_o) != exp_addr || hv_sup_o || ce_n_o) v_scan++;
            exp_addr++;
         end else begin
            exp_addr = 0;
         end
         if (done_o) begin
            n_done++;
            if (busy_o) v_done++;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary_and_end();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic run_case(input int meth, input int need, input int bad,
                           input int exp_pass, input int exp_tries, input int exp_reads,
                           input int exp_short, input int exp_long, input bit poke);
      int s_short = n_short, s_long = n_long, s_reads = n_reads, s_done = n_done;
      int s_viol = v_strobe + v_hold + v_cmd + v_hv + v_width + v_scan + v_done;
      erase_base = n_long; need_erases = need; bad_addr = bad; cur_method = meth;
      @(negedge clk);
      method_i = meth[0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2: accepted start, programming supply up, strobe still high
      chk("R2", "busy after start", busy_o, 1);
      chk("R2", "attempts after start", attempts_o, 1);
      chk("R2", "hv_sup after start", hv_sup_o, 1);
      chk("R2", "strobe high during setup", pgm_n_o, 1);
      if (poke) begin
         repeat (40) @(negedge clk);
         start_i = 1'b1;               // R10: must be ignored
         @(negedge clk);
         start_i = 1'b0;
      end
      while (!done_o) @(negedge clk);
      chk("R8", "pass at done", pass_o, exp_pass);
      chk(exp_pass ? "R8" : "R9", "attempts at done", attempts_o, exp_tries);
      chk("R7", "reads in run", n_reads - s_reads, exp_reads);
      chk("R4", "short strobes", n_short - s_short, exp_short);
      chk(poke ? "R10" : "R3", "long strobes", n_long - s_long, exp_long);
      chk("R5", "protocol violations",
          v_strobe + v_hold + v_cmd + v_hv + v_width + v_scan + v_done - s_viol, 0);
      repeat (5) @(negedge clk);
      chk("R11", "single done pulse", n_done - s_done, 1);
      chk("R11", "idle after done", busy_o, 0);
      chk("R11", "pass held", pass_o, exp_pass);
      chk("R11", "attempts held", attempts_o, exp_tries);
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk("R1", "busy", busy_o, 0);
      chk("R1", "done", done_o, 0);
      chk("R1", "pass", pass_o, 0);
      chk("R1", "attempts", attempts_o, 0);
      chk("R1", "ce_n/oe_n/pgm_n", {ce_n_o, oe_n_o, pgm_n_o}, 3'b111);
      chk("R1", "hv_sup/a9", {hv_sup_o, a9_hv_o}, 2'b00);
   endtask

   // R3 R8: high-voltage method, blank after one erase
   task automatic test_hv_single();
      run_case(0, 1, 0, 1, 1, DEPTH, 0, 1, 1'b0);
   endtask

   // R4 R6 R7: command method, blank after three erases, dirty at address 10
   task automatic test_cmd_retry();
      run_case(1, 3, 10, 1, 3, 2 * 11 + DEPTH, 3, 3, 1'b0);
   endtask

   // R9: never blank, dirty at address 0
   task automatic test_give_up();
      run_case(0, 1000, 0, 0, MAXT, MAXT, 0, MAXT, 1'b0);
   endtask

   // R7 R10: dirty at last address on first pass, start poked mid-run
   task automatic test_last_addr_poke();
      run_case(0, 2, DEPTH - 1, 1, 2, 2 * DEPTH, 0, 2, 1'b1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
      summary_and_end();
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_reset();
      test_hv_single();
      test_cmd_retry();
      test_give_up();
      test_last_addr_poke();
      summary_and_end();
   end

endmodule